// File: doc/BRIEF.md
# Multi-core boot hold controller

This block is a small register file on a 32-bit memory-mapped bus that decides when each of up to two processor cores may start after a system reset. Each core has one hold bit in a shared wait register. A core whose hold bit is 1 when system reset ends stays powered off. Software starts it by clearing the bit. Each 1-to-0 change of a hold bit turns that core's run output on and sends it a one-cycle reset pulse. Setting a hold bit again never stops a core that is already running.

Each core also has a boot vector register. It holds the address from which the core fetches its initial stack pointer and entry point. The core sees this value on a vector output that is loaded only when the core's reset pulse is issued, so rewriting the register has no effect on a running core. A parameter chooses the single-core or the dual-core build. In the single-core build the second core's vector register does not exist. The map also holds a sticky debug status word, which is filled through a separate set register, and four read-only identification bytes.

Top module: `boot_hold_ctrl`

## Requirements
- R1: The wait register is at offset 0x010, with bit i controlling core i (1 = held off). It resets to 0 in the single-core build and to WAIT_RST_DUAL (default 2'b10) in the dual-core build. Unused bits read as 0.
- R2: Directly after reset ends, core_run[i] equals the inverse of core i's wait reset bit, and core_rst_pulse is 0.
- R3: A write that changes wait bit i from 1 to 0 drives core_rst_pulse[i] high for exactly the one cycle after the write. core_run[i] is high from that cycle until system reset.
- R4: Writing 1 to a running core's wait bit leaves core_run[i] high and the stored bit becomes 1. A write that keeps a bit at 0, or that sets it to 1, gives no pulse.
- R5: The boot vector registers are at 0x020 (core 0) and 0x024 (core 1). They can be read and written, and they reset to 0x10000000.
- R6: core_vtor[32*i+31:32*i] resets to 0x10000000 and changes only in the cycle of core i's reset pulse, when it takes the vector register value that was held at the releasing write.
- R7: In the single-core build, offset 0x024 is an invalid address. Wait bit 1 reads as 0 and writes to it are ignored.
- R8: The debug status word at 0x000 is read-only and resets to 0. Each write to 0x004 ORs its data into it. Reading 0x004 returns 0.
- R9: The identification bytes at 0xFF0, 0xFF4, 0xFF8 and 0xFFC read as 0x0D, 0xF0, 0x05 and 0xB1 in bits 7:0, with the upper bits 0. Writes to them are ignored.
- R10: Read data appears on bus_rdata in the cycle after the access. An unmapped or misaligned address (bus_addr[1:0] != 0) reads as 0, ignores writes, and raises bus_err for the one cycle after that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Invalid-address flag, the cycle after the access |
| core_run | output | NUM_CORES | Per-core power/run enable |
| core_rst_pulse | output | NUM_CORES | Per-core one-cycle reset pulse |
| core_vtor | output | 32*NUM_CORES | Per-core boot vector seen by the core |

## Verification
The assertions assume at most one bus access per cycle. They also assume that system reset is held for at least one clock edge before any check applies, so the run and vector outputs start from their reset values. Stimulus changes inputs only on the falling edge and issues one access at a time, with the select dropped between accesses. So each write has exactly one cycle in which it can take effect, and each pulse can be seen falling back to zero. Both builds are driven from the same reset, each on its own select line.

// File: rtl/boot_hold_pkg.sv
// Package: shared constants, register selector type and ID byte function
// for the boot hold controller. Assumes 32-bit word-aligned registers.
package boot_hold_pkg;

    localparam int DATA_W    = 32;
    localparam int MAX_CORES = 2;

    localparam logic [11:0] OFF_DBG_STAT = 12'h000;
    localparam logic [11:0] OFF_DBG_SET  = 12'h004;
    localparam logic [11:0] OFF_WAIT     = 12'h010;
    localparam logic [11:0] OFF_VTOR0    = 12'h020;
    localparam logic [11:0] OFF_VTOR1    = 12'h024;
    localparam logic [11:0] OFF_CID_BASE = 12'hFF0;

    typedef enum logic [2:0] {
        SEL_NONE     = 3'd0,
        SEL_DBG_STAT = 3'd1,
        SEL_DBG_SET  = 3'd2,
        SEL_WAIT     = 3'd3,
        SEL_VTOR0    = 3'd4,
        SEL_VTOR1    = 3'd5,
        SEL_CID      = 3'd6
    } reg_sel_e;

    // Identification byte for index 0..3.
    function automatic logic [7:0] cid_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    cid_byte = 8'h0D;
            2'd1:    cid_byte = 8'hF0;
            2'd2:    cid_byte = 8'h05;
            default: cid_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/bh_addr_decode.sv
// Module: bh_addr_decode
// Maps a byte offset to a register selector. Misaligned offsets and
// offsets the build does not implement give SEL_NONE.
// Assumes ADDR_W >= 12 so that the identification bytes can be reached.
module bh_addr_decode
    import boot_hold_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter bit DUAL_CORE = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [1:0]        cid_idx
);

    localparam logic [ADDR_W-1:0] A_DBG_STAT = ADDR_W'(OFF_DBG_STAT);
    localparam logic [ADDR_W-1:0] A_DBG_SET  = ADDR_W'(OFF_DBG_SET);
    localparam logic [ADDR_W-1:0] A_WAIT     = ADDR_W'(OFF_WAIT);
    localparam logic [ADDR_W-1:0] A_VTOR0    = ADDR_W'(OFF_VTOR0);
    localparam logic [ADDR_W-1:0] A_VTOR1    = ADDR_W'(OFF_VTOR1);
    localparam logic [ADDR_W-1:0] A_CID      = ADDR_W'(OFF_CID_BASE);

    logic [ADDR_W-1:0] cid_off;

    // Offset of the access relative to the ID byte block.
    assign cid_off = addr - A_CID;
    assign cid_idx = cid_off[3:2];

    // Selector lookup, including the alignment and build checks.
    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr == A_DBG_STAT)                     sel = SEL_DBG_STAT;
            else if (addr == A_DBG_SET)                 sel = SEL_DBG_SET;
            else if (addr == A_WAIT)                    sel = SEL_WAIT;
            else if (addr == A_VTOR0)                   sel = SEL_VTOR0;
            else if (addr == A_VTOR1 && DUAL_CORE)      sel = SEL_VTOR1;
            else if (addr >= A_CID && cid_off < ADDR_W'(16)) sel = SEL_CID;
        end
    end

endmodule

// File: rtl/bh_core_slot.sv
// Module: bh_core_slot
// Per-core state: the wait bit, the boot vector register, the run enable,
// the one-cycle reset pulse, and the vector the core sees. A release is a
// write that takes the wait bit from 1 to 0. Assumes at most one write
// strobe per cycle.
module bh_core_slot #(
    parameter int          DATA_W   = 32,
    parameter bit          WAIT_RST = 1'b0,
    parameter logic [31:0] VTOR_RST = 32'h1000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_we,
    input  logic              wait_wbit,
    input  logic              vtor_we,
    input  logic [DATA_W-1:0] vtor_wdata,
    output logic              wait_bit,
    output logic [DATA_W-1:0] vtor_reg,
    output logic              run,
    output logic              rst_pulse,
    output logic [DATA_W-1:0] vtor_out
);

    logic release_now;

    // A release is a 1-to-0 write to the wait bit.
    assign release_now = wait_we & wait_bit & ~wait_wbit;

    // Stored wait bit. Software may set or clear it freely.
    always_ff @(posedge clk) begin
        if (!rst_n)       wait_bit <= WAIT_RST;
        else if (wait_we) wait_bit <= wait_wbit;
    end

    // Run enable: starts at the inverse of the reset hold, set by a release.
    always_ff @(posedge clk) begin
        if (!rst_n)           run <= ~WAIT_RST;
        else if (release_now) run <= 1'b1;
    end

    // One-cycle reset pulse in the cycle after a release.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= release_now;
    end

    // Software-visible boot vector register.
    always_ff @(posedge clk) begin
        if (!rst_n)       vtor_reg <= DATA_W'(VTOR_RST);
        else if (vtor_we) vtor_reg <= vtor_wdata;
    end

    // Vector seen by the core, loaded only when the core is reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           vtor_out <= DATA_W'(VTOR_RST);
        else if (release_now) vtor_out <= vtor_reg;
    end

endmodule

// File: rtl/bh_dbg_status.sv
// Module: bh_dbg_status
// Sticky debug status word. Each write to the set register ORs its data
// in. Only system reset clears it.
module bh_dbg_status #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic [DATA_W-1:0] set_data,
    output logic [DATA_W-1:0] status
);

    // Accumulate the bits written to the set register.
    always_ff @(posedge clk) begin
        if (!rst_n)      status <= '0;
        else if (set_we) status <= status | set_data;
    end

endmodule

// File: rtl/boot_hold_ctrl.sv
// Module: boot_hold_ctrl
// Top of the boot hold controller. Decodes single-cycle bus accesses,
// holds one core slot per core built, and returns registered read data
// and an error flag in the cycle after each access. Assumes one access
// per cycle and a synchronous active-low reset.
module boot_hold_ctrl
    import boot_hold_pkg::*;
#(
    parameter int          ADDR_W        = 12,
    parameter bit          DUAL_CORE     = 1'b1,
    parameter logic [1:0]  WAIT_RST_DUAL = 2'b10,
    parameter logic [31:0] VTOR_RST      = 32'h1000_0000,
    localparam int         NUM_CORES     = DUAL_CORE ? 2 : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        bus_err,
    output logic [NUM_CORES-1:0]        core_run,
    output logic [NUM_CORES-1:0]        core_rst_pulse,
    output logic [NUM_CORES*DATA_W-1:0] core_vtor
);

    localparam logic [1:0] WAIT_RST = DUAL_CORE ? WAIT_RST_DUAL : 2'b00;

    reg_sel_e                 sel;
    logic [1:0]               cid_idx;
    logic                     do_wr;
    logic                     do_rd;
    logic [MAX_CORES-1:0]     wait_bits;
    logic [DATA_W-1:0]        vtor_regs [MAX_CORES];
    logic [DATA_W-1:0]        dbg_stat;
    logic [DATA_W-1:0]        rd_mux;

    bh_addr_decode #(
        .ADDR_W    (ADDR_W),
        .DUAL_CORE (DUAL_CORE)
    ) dec_i (
        .addr    (bus_addr),
        .sel     (sel),
        .cid_idx (cid_idx)
    );

    // Qualified read and write strobes.
    assign do_wr = bus_sel & bus_write;
    assign do_rd = bus_sel & ~bus_write;

    bh_dbg_status #(
        .DATA_W (DATA_W)
    ) dbg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (do_wr && sel == SEL_DBG_SET),
        .set_data (bus_wdata),
        .status   (dbg_stat)
    );

    // One slot per core built; missing cores read as zero.
    for (genvar i = 0; i < MAX_CORES; i++) begin : g_core
        if (i < NUM_CORES) begin : g_slot
            logic vtor_sel;
            assign vtor_sel = (i == 0) ? (sel == SEL_VTOR0) : (sel == SEL_VTOR1);
            bh_core_slot #(
                .DATA_W   (DATA_W),
                .WAIT_RST (WAIT_RST[i]),
                .VTOR_RST (VTOR_RST)
            ) slot_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .wait_we    (do_wr && sel == SEL_WAIT),
                .wait_wbit  (bus_wdata[i]),
                .vtor_we    (do_wr && vtor_sel),
                .vtor_wdata (bus_wdata),
                .wait_bit   (wait_bits[i]),
                .vtor_reg   (vtor_regs[i]),
                .run        (core_run[i]),
                .rst_pulse  (core_rst_pulse[i]),
                .vtor_out   (core_vtor[i*DATA_W +: DATA_W])
            );
        end else begin : g_absent
            assign wait_bits[i] = 1'b0;
            assign vtor_regs[i] = '0;
        end
    end

    // Read data selection for the decoded register.
    always_comb begin
        case (sel)
            SEL_DBG_STAT: rd_mux = dbg_stat;
            SEL_WAIT:     rd_mux = DATA_W'(wait_bits);
            SEL_VTOR0:    rd_mux = vtor_regs[0];
            SEL_VTOR1:    rd_mux = vtor_regs[1];
            SEL_CID:      rd_mux = DATA_W'(cid_byte(cid_idx));
            default:      rd_mux = '0;
        endcase
    end

    // Registered read data, zero for writes and idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (do_rd) bus_rdata <= rd_mux;
        else            bus_rdata <= '0;
    end

    // Registered error flag for accesses to no register.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= bus_sel && sel == SEL_NONE;
    end

endmodule

// File: rtl/boot_hold_ctrl_chk.sv
// Module: boot_hold_ctrl_chk
// Port-level properties of the boot hold controller, bound to the top.
// Assumes reset is applied at the first clock edge.
module boot_hold_ctrl_chk #(
    parameter int DUAL_CORE = 1,
    parameter int DATA_W    = 32,
    localparam int NC       = DUAL_CORE ? 2 : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 bus_err,
    input logic [NC-1:0]        core_run,
    input logic [NC-1:0]        core_rst_pulse,
    input logic [NC*DATA_W-1:0] core_vtor
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_pulse != '0) |=> ((core_rst_pulse & $past(core_rst_pulse)) == '0)); // R3

    AST_RUN_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(core_run) & ~core_run) == '0)); // R4

    AST_PULSE_WITH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_rst_pulse & ~core_run) == '0)); // R3

    AST_VTOR_ONLY_AT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_pulse == '0) |-> $stable(core_vtor)); // R6

    AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel)); // R10

    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0)); // R10

endmodule

bind boot_hold_ctrl boot_hold_ctrl_chk #(
    .DUAL_CORE (DUAL_CORE ? 1 : 0),
    .DATA_W    (32)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_sel        (bus_sel),
    .bus_rdata      (bus_rdata),
    .bus_err        (bus_err),
    .core_run       (core_run),
    .core_rst_pulse (core_rst_pulse),
    .core_vtor      (core_vtor)
);

// File: tb/boot_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: drives a dual-core build (dut_i) and a single-core build (dut1_i)
// from one bus, each on its own select. Expected values come from a
// bench-side model of the release rule.
module boot_hold_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_d = 1'b0, sel_s = 1'b0;
    logic        bwr = 1'b0;
    logic [11:0] baddr = '0;
    logic [31:0] bwdata = '0;

    logic [31:0] rd_d, rd_s;
    logic        err_d, err_s;
    logic [1:0]  run_d, pls_d;
    logic [63:0] vt_d;
    logic [0:0]  run_s, pls_s;
    logic [31:0] vt_s;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    boot_hold_ctrl #(.DUAL_CORE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_d), .bus_write(bwr),
        .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(rd_d), .bus_err(err_d),
        .core_run(run_d), .core_rst_pulse(pls_d), .core_vtor(vt_d));

    boot_hold_ctrl #(.DUAL_CORE(1'b0)) dut1_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_s), .bus_write(bwr),
        .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(rd_s), .bus_err(err_s),
        .core_run(run_s), .core_rst_pulse(pls_s), .core_vtor(vt_s));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One access on the chosen build; returns at the falling edge where
    // the registered response and the write's effects are visible.
    task automatic access(input bit single, input bit wr, input logic [11:0] a,
                          input logic [31:0] d, output logic [31:0] rdata,
                          output logic err);
        @(negedge clk);
        sel_d = ~single; sel_s = single;
        bwr = wr; baddr = a; bwdata = d;
        @(negedge clk);
        sel_d = 1'b0; sel_s = 1'b0; bwr = 1'b0;
        rdata = single ? rd_s : rd_d;
        err   = single ? err_s : err_d;
    endtask

    logic [31:0] r;
    logic        e;
    logic [1:0]  run_m, exp_p;

    initial begin
        do_reset();
        // Reset state of both builds.
        chk("R2 dual run after reset", run_d, 2'b01);
        chk("R2 dual pulse after reset", pls_d, 2'b00);
        chk("R2 single run after reset", run_s, 1'b1);
        chk("R6 dual vector reset", vt_d, 64'h1000_0000_1000_0000);
        chk("R6 single vector reset", vt_s, 32'h1000_0000);
        access(0, 0, 12'h010, 0, r, e); chk("R1 dual wait reset", r, 32'h2);
        access(1, 0, 12'h010, 0, r, e); chk("R1 single wait reset", r, 32'h0);
        access(0, 0, 12'h020, 0, r, e); chk("R5 vector 0 reset", r, 32'h1000_0000);
        access(0, 0, 12'h024, 0, r, e); chk("R5 vector 1 reset", r, 32'h1000_0000);

        // Exhaustive two-write sweep of the wait register on the dual build.
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 4; n++) begin
                do_reset();
                run_m = 2'b01;
                access(0, 1, 12'h010, 32'(o), r, e);
                exp_p = 2'b10 & ~2'(o);
                chk("R3 pulse after first write", pls_d, exp_p);
                run_m = run_m | exp_p;
                chk("R3 run after first write", run_d, run_m);
                access(0, 1, 12'h010, 32'(n), r, e);
                exp_p = 2'(o) & ~2'(n);
                chk("R4 pulse only on 1-to-0", pls_d, exp_p);
                run_m = run_m | exp_p;
                chk("R4 run never stops", run_d, run_m);
                @(negedge clk);
                chk("R3 pulse lasts one cycle", pls_d, 2'b00);
                access(0, 0, 12'h010, 0, r, e);
                chk("R4 stored wait value", r, 32'(n));
            end
        end

        // Vector capture at the core's reset.
        do_reset();
        access(0, 1, 12'h024, 32'h2000_0100, r, e);
        chk("R6 vector 1 held before release", vt_d[63:32], 32'h1000_0000);
        access(0, 1, 12'h010, 32'h0, r, e);
        chk("R6 vector 1 loaded at release", vt_d[63:32], 32'h2000_0100);
        chk("R6 vector 0 untouched", vt_d[31:0], 32'h1000_0000);
        access(0, 1, 12'h024, 32'h3000_0000, r, e);
        @(negedge clk);
        chk("R6 running core keeps vector", vt_d[63:32], 32'h2000_0100);
        access(0, 0, 12'h024, 0, r, e); chk("R5 vector 1 readback", r, 32'h3000_0000);
        access(0, 1, 12'h010, 32'h2, r, e);
        access(0, 1, 12'h010, 32'h0, r, e);
        chk("R6 vector 1 reloaded", vt_d[63:32], 32'h3000_0000);
        access(0, 1, 12'h020, 32'h0404_0000, r, e);
        access(0, 1, 12'h010, 32'h1, r, e);
        access(0, 1, 12'h010, 32'h0, r, e);
        chk("R6 vector 0 loaded", vt_d[31:0], 32'h0404_0000);
        chk("R3 core 0 pulse on restart", pls_d, 2'b01);

        // Single-core build: missing second core.
        access(1, 0, 12'h024, 0, r, e);
        chk("R7 single vector 1 read err", e, 1'b1);
        chk("R7 single vector 1 read data", r, 32'h0);
        access(1, 1, 12'h024, 32'hFFFF_FFFF, r, e);
        chk("R7 single vector 1 write err", e, 1'b1);
        access(1, 1, 12'h010, 32'h3, r, e);
        chk("R7 wait write not an error", e, 1'b0);
        access(1, 0, 12'h010, 0, r, e);
        chk("R7 wait bit 1 ignored", r, 32'h1);
        chk("R4 single core still runs", run_s, 1'b1);
        access(1, 1, 12'h010, 32'h0, r, e);
        chk("R3 single core pulse", pls_s, 1'b1);
        access(1, 0, 12'h020, 0, r, e);
        chk("R7 vector 0 still valid", e, 1'b0);

        // Debug status accumulation.
        access(0, 0, 12'h000, 0, r, e); chk("R8 debug status reset", r, 32'h0);
        access(0, 1, 12'h004, 32'h5, r, e);
        access(0, 1, 12'h004, 32'h8000_0002, r, e);
        access(0, 0, 12'h000, 0, r, e); chk("R8 debug status sticky OR", r, 32'h8000_0007);
        access(0, 1, 12'h000, 32'h0, r, e);
        access(0, 0, 12'h000, 0, r, e); chk("R8 debug status read-only", r, 32'h8000_0007);
        access(0, 0, 12'h004, 0, r, e); chk("R8 set register reads 0", r, 32'h0);

        // Identification bytes.
        for (int k = 0; k < 4; k++) begin
            logic [7:0] expb;
            expb = (k == 0) ? 8'h0D : (k == 1) ? 8'hF0 : (k == 2) ? 8'h05 : 8'hB1;
            access(0, 0, 12'(12'hFF0 + 4 * k), 0, r, e);
            chk("R9 id byte", r, 32'(expb));
            chk("R9 id no error", e, 1'b0);
        end
        access(0, 1, 12'hFF0, 32'h55, r, e);
        access(0, 0, 12'hFF0, 0, r, e); chk("R9 id write ignored", r, 32'h0D);

        // Invalid and misaligned offsets.
        access(0, 0, 12'h100, 0, r, e);
        chk("R10 unmapped read err", e, 1'b1);
        chk("R10 unmapped read data", r, 32'h0);
        access(0, 1, 12'h012, 32'h0, r, e);
        chk("R10 misaligned write err", e, 1'b1);
        access(0, 0, 12'h010, 0, r, e);
        chk("R10 misaligned write ignored", r, 32'h0);
        @(negedge clk);
        chk("R10 err lasts one cycle", err_d, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule